// File: doc/BRIEF.md
# Companded Two-Party Sample Summer

This block mixes two voice channels for a conference bridge. Each channel arrives as an 8-bit companded sample: a sign, a 3-bit exponent and a 4-bit mantissa on a logarithmic scale. Companded bytes cannot go through an ordinary binary adder, so each operand is first expanded to a 14-bit signed linear value. The two linear values are added at 15 bits, where the sum cannot overflow. A sum whose magnitude is too large for one companded byte is clamped, and the result is compressed back to a single companded byte.

A caller presents both operand bytes with a single valid strobe. The block is a two-stage pipeline. Stage one expands both operands and adds them. Stage two saturates the sum and compresses it. The block accepts a new pair on every clock and returns each result two clocks later, with its own valid strobe.

Top module: `mulaw_pair_sum`

## Requirements
- R1: Code format. Bit 7 is the sign (1 = negative), bits 6:4 are the exponent E and bits 3:0 are the mantissa M. A code stands for the linear value (1-2*sign)*((2M+33)*2^E - 33), which gives magnitudes from 0 to 8031.
- R2: The two operands are expanded per R1 and added exactly in the linear domain. When the sum x has |x| <= 8031, the output code is the (E,M) for which (M+16)*2^(E+1) - 33 <= |x| < (M+17)*2^(E+1) - 33, and its sign bit is set exactly when x < 0.
- R3: A linear sum with magnitude above 8031 is clamped to 8031 and keeps its sign, so it gives 0x7F (positive) or 0xFF (negative). The result never wraps.
- R4: A zero linear sum always gives code 0x00. This includes two zeros of either sign and two operands that cancel.
- R5: Swapping the two operands gives the same output byte.
- R6: out_vld is in_vld delayed by exactly two clock cycles. out_code carries the result of the pair that was presented with that in_vld.
- R7: While rst_n is low at a clock edge, out_vld and out_code are both cleared to 0 at that edge. rst_n is synchronous and active low.
- R8: A new operand pair is accepted on every cycle. Back-to-back pairs each produce a result on consecutive cycles.
- R9: out_code changes only in cycles where out_vld is high. Operands presented while in_vld is low have no effect on out_code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_vld | input | 1 | Operand pair valid |
| in_a | input | 8 | First companded operand |
| in_b | input | 8 | Second companded operand |
| out_vld | output | 1 | Result valid, two cycles after in_vld |
| out_code | output | 8 | Companded sum |

## Verification
The bench builds the block with its default clamp limit of 8031, which is the largest magnitude a code can represent. At that limit every one of the 65536 operand pairs can be streamed back to back and compared with a reference model. The reference encodes by searching the decision intervals, not by locating leading bits. Streaming all pairs reaches every exponent boundary, every saturating pair, and every cancelling or negative-zero pair.

// File: rtl/mulaw_sum_pkg.sv
// Shared constants and types for the companded sample summer.
// Assumes the 8-bit code layout sign/exponent/mantissa described in the brief.
package mulaw_sum_pkg;
    localparam int EXP_W   = 3;
    localparam int MAN_W   = 4;
    localparam int CODE_W  = 1 + EXP_W + MAN_W;
    localparam int MAG_W   = 13;
    localparam int LIN_W   = MAG_W + 1;
    localparam int SUM_W   = LIN_W + 1;
    localparam int BIAS    = 33;
    localparam int MAG_MAX = 8031;
    localparam int SEG_LSB = MAN_W + 1;
    localparam int N_OPS   = 2;

    typedef struct packed {
        logic             neg;
        logic [EXP_W-1:0] ex;
        logic [MAN_W-1:0] man;
    } code_t;

    typedef logic signed [LIN_W-1:0] lin_t;
    typedef logic signed [SUM_W-1:0] sum_t;
endpackage

// File: rtl/mulaw_expand.sv
// Expands one companded code to a signed linear value.
// Purely combinational; assumes the code layout in mulaw_sum_pkg.
module mulaw_expand
    import mulaw_sum_pkg::*;
(
    input  code_t code,
    output lin_t  lin
);
    logic [MAG_W-1:0] seg_base;
    logic [MAG_W-1:0] shifted;
    logic [MAG_W-1:0] mag;

    // Builds (2M+33) << E - 33, then applies the sign.
    always_comb begin
        seg_base = {{(MAG_W-MAN_W-2){1'b0}}, 1'b1, code.man, 1'b1};
        shifted  = seg_base << code.ex;
        mag      = shifted - MAG_W'(BIAS);
        lin      = code.neg ? -$signed({1'b0, mag}) : $signed({1'b0, mag});
    end
endmodule

// File: rtl/lin_saturate.sv
// Splits a wide signed sum into sign and magnitude, clamping the magnitude.
// Assumes CLAMP fits in MAG_W bits.
module lin_saturate
    import mulaw_sum_pkg::*;
#(
    parameter int CLAMP = MAG_MAX
) (
    input  sum_t             sum,
    output logic             neg,
    output logic [MAG_W-1:0] mag
);
    logic [SUM_W-1:0] abs_v;

    // Takes the absolute value and limits it to CLAMP.
    always_comb begin
        neg   = sum[SUM_W-1];
        abs_v = neg ? SUM_W'(-sum) : SUM_W'(sum);
        mag   = (abs_v > SUM_W'(CLAMP)) ? MAG_W'(CLAMP) : abs_v[MAG_W-1:0];
    end
endmodule

// File: rtl/mulaw_compress.sv
// Compresses a sign and magnitude to a companded code.
// Assumes the magnitude is at most MAG_MAX, so mag+BIAS fits MAG_W bits.
module mulaw_compress
    import mulaw_sum_pkg::*;
(
    input  logic             neg,
    input  logic [MAG_W-1:0] mag,
    output code_t            code
);
    logic [MAG_W-1:0] biased;
    logic [EXP_W-1:0] seg;
    logic [MAG_W-1:0] sh;

    // Finds the leading segment bit of the biased magnitude and extracts the mantissa.
    always_comb begin
        biased = mag + MAG_W'(BIAS);
        seg    = '0;
        for (int i = 0; i < (1 << EXP_W); i++) begin
            if (biased[i + SEG_LSB]) seg = EXP_W'(i);
        end
        sh        = biased >> ({1'b0, seg} + 4'd1);
        code.neg  = neg;
        code.ex   = seg;
        code.man  = sh[MAN_W-1:0];
    end
endmodule

// File: rtl/mulaw_pair_sum.sv
// Two-stage pipelined sum of two companded samples.
// Stage 1 expands both operands and adds them; stage 2 saturates and compresses.
// Assumes synchronous active-low reset and one shared valid for both operands.
module mulaw_pair_sum
    import mulaw_sum_pkg::*;
#(
    parameter int CLAMP_MAG = MAG_MAX
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_vld,
    input  logic [CODE_W-1:0] in_a,
    input  logic [CODE_W-1:0] in_b,
    output logic              out_vld,
    output logic [CODE_W-1:0] out_code
);
    code_t op_code [N_OPS];
    lin_t  op_lin  [N_OPS];

    assign op_code[0] = code_t'(in_a);
    assign op_code[1] = code_t'(in_b);

    for (genvar g = 0; g < N_OPS; g++) begin : g_expand
        mulaw_expand u_expand (
            .code (op_code[g]),
            .lin  (op_lin[g])
        );
    end

    logic s1_vld;
    sum_t s1_sum;

    // Stage 1: registers the exact linear sum of a valid pair.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_vld <= 1'b0;
            s1_sum <= '0;
        end else begin
            s1_vld <= in_vld;
            if (in_vld) s1_sum <= sum_t'(op_lin[0]) + sum_t'(op_lin[1]);
        end
    end

    logic             sat_neg;
    logic [MAG_W-1:0] sat_mag;
    code_t            enc_code;

    lin_saturate #(.CLAMP(CLAMP_MAG)) u_sat (
        .sum (s1_sum),
        .neg (sat_neg),
        .mag (sat_mag)
    );

    mulaw_compress u_comp (
        .neg  (sat_neg),
        .mag  (sat_mag),
        .code (enc_code)
    );

    // Stage 2: registers the compressed result; holds it across bubbles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_vld  <= 1'b0;
            out_code <= '0;
        end else begin
            out_vld <= s1_vld;
            if (s1_vld) out_code <= enc_code;
        end
    end
endmodule

// File: rtl/mulaw_pair_sum_chk.sv
// Assertion checker for mulaw_pair_sum, attached by bind below.
// Observes only the ports of the block.
module mulaw_pair_sum_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       in_vld,
    input logic [7:0] in_a,
    input logic [7:0] in_b,
    input logic       out_vld,
    input logic [7:0] out_code
);
    assert_valid_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |-> ##2 out_vld);

    assert_valid_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |-> ##2 !out_vld);

    assert_reset_clear_R7: assert property (@(posedge clk)
        !rst_n |=> (!out_vld && out_code == 8'h00));

    assert_hold_code_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && $past(rst_n) && out_code != $past(out_code)) |-> out_vld);

    // Two top-segment operands of one sign always exceed the limit.
    assert_clamp_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_vld && $past(in_a[6:4] == 3'd7 && in_b[6:4] == 3'd7 && in_a[7] == in_b[7], 2))
        |-> (out_code[6:0] == 7'h7F && out_code[7] == $past(in_a[7], 2)));

    assert_zero_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_vld && $past(in_a[6:0] == in_b[6:0] && (in_a[7] != in_b[7] || in_a[6:0] == 7'h00), 2))
        |-> out_code == 8'h00);
endmodule

bind mulaw_pair_sum mulaw_pair_sum_chk chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_vld   (in_vld),
    .in_a     (in_a),
    .in_b     (in_b),
    .out_vld  (out_vld),
    .out_code (out_code)
);

// File: tb/mulaw_pair_sum_tb_top.sv
`timescale 1ns/1ps
module mulaw_pair_sum_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_vld = 1'b0;
    logic [7:0] in_a = 8'h00;
    logic [7:0] in_b = 8'h00;
    logic       out_vld;
    logic [7:0] out_code;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    mulaw_pair_sum dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_vld   (in_vld),
        .in_a     (in_a),
        .in_b     (in_b),
        .out_vld  (out_vld),
        .out_code (out_code)
    );

    // Directed vectors {a, b, expected} worked out by hand from R1..R4.
    localparam logic [23:0] VEC [0:12] = '{
        {8'h00, 8'h00, 8'h00},   // R4 zero + zero
        {8'h7F, 8'h7F, 8'h7F},   // R3 positive clamp
        {8'hFF, 8'hFF, 8'hFF},   // R3 negative clamp
        {8'h7F, 8'hFF, 8'h00},   // R4 full-scale cancel
        {8'h01, 8'h00, 8'h01},   // R2 smallest step
        {8'h01, 8'h01, 8'h02},   // R2 sum 4
        {8'h0F, 8'h0F, 8'h17},   // R2 crosses into segment 1
        {8'h70, 8'h70, 8'h7F},   // R3 sum 8382
        {8'h70, 8'h00, 8'h70},   // R2 top segment base
        {8'h85, 8'h05, 8'h00},   // R4 cancel
        {8'h90, 8'h00, 8'h90},   // R2 negative value
        {8'h80, 8'h80, 8'h00},   // R4 negative zeros
        {8'h20, 8'h92, 8'h16}    // R2 mixed signs, sum 58
    };

    // Counts one check and reports a failure line.
    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Reference decode following the R1 formula.
    function automatic int ref_decode(input logic [7:0] c);
        int m;
        m = ((2 * int'(c[3:0]) + 33) << c[6:4]) - 33;
        return c[7] ? -m : m;
    endfunction

    // Reference encode by searching R2 decision intervals, after R3 clamping.
    function automatic logic [7:0] ref_encode(input int x);
        int m;
        int best;
        m = (x < 0) ? -x : x;
        if (m > 8031) m = 8031;
        best = 0;
        for (int k = 0; k < 128; k++) begin
            if ((((k & 15) + 16) << ((k >> 4) + 1)) - 33 <= m) best = k;
        end
        return {(x < 0), 7'(best)};
    endfunction

    function automatic logic [7:0] ref_sum(input logic [7:0] a, input logic [7:0] b);
        return ref_encode(ref_decode(a) + ref_decode(b));
    endfunction

    // Presents one pair alone and returns the output sampled two cycles later.
    task automatic run_pair(input logic [7:0] a, input logic [7:0] b, output logic [7:0] got, output logic vld);
        @(negedge clk);
        in_vld = 1'b1; in_a = a; in_b = b;
        @(negedge clk);
        in_vld = 1'b0; in_a = ~a; in_b = ~b;
        @(negedge clk);
        got = out_code;
        vld = out_vld;
    endtask

    initial begin : watchdog
        #(5.0 * 190000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        logic [7:0] got;
        logic [7:0] got2;
        logic       vld;
        logic [7:0] e_new;
        logic [7:0] e_old;

        repeat (3) @(negedge clk);
        // R7: state after reset.
        check(out_vld == 1'b0, "R7 out_vld after reset", out_vld, 0);
        check(out_code == 8'h00, "R7 out_code after reset", out_code, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Directed vectors (R2, R3, R4, R6).
        for (int i = 0; i < 13; i++) begin
            run_pair(VEC[i][23:16], VEC[i][15:8], got, vld);
            check(vld == 1'b1, "R6 out_vld two cycles after in_vld", vld, 1);
            check(got == VEC[i][7:0], "R2/R3/R4 directed vector", got, VEC[i][7:0]);
        end

        // R6: valid drops one cycle after a lone result.
        @(negedge clk);
        check(out_vld == 1'b0, "R6 out_vld single pulse", out_vld, 0);

        // R9: idle operands change while in_vld is low; out_code holds.
        run_pair(8'h33, 8'h44, got, vld);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            in_a = 8'(i * 37); in_b = 8'(i * 91);
            check(out_code == got, "R9 out_code holds while idle", out_code, got);
            check(out_vld == 1'b0, "R9 out_vld low while idle", out_vld, 0);
        end

        // R5: swapped operands give identical bytes.
        for (int i = 0; i < 6; i++) begin
            logic [7:0] a;
            logic [7:0] b;
            a = 8'(i * 45 + 3);
            b = 8'(i * 29 + 200);
            run_pair(a, b, got, vld);
            run_pair(b, a, got2, vld);
            check(got == got2, "R5 commutative", got2, got);
        end

        // R8, R2: all 65536 pairs streamed back to back.
        e_new = 8'h00;
        e_old = 8'h00;
        for (int n = 0; n < 65538; n++) begin
            @(negedge clk);
            if (n >= 2) begin
                check(out_vld == 1'b1, "R8 streaming valid", out_vld, 1);
                check(out_code == e_old, "R2 exhaustive pair", out_code, e_old);
            end
            e_old = e_new;
            if (n < 65536) begin
                in_vld = 1'b1;
                in_a = 8'(n >> 8);
                in_b = 8'(n);
                e_new = ref_sum(8'(n >> 8), 8'(n));
            end else begin
                in_vld = 1'b0;
            end
        end

        // R7: reset in mid-stream clears the outputs.
        @(negedge clk);
        in_vld = 1'b1; in_a = 8'h55; in_b = 8'h22;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(out_vld == 1'b0, "R7 mid-run reset valid", out_vld, 0);
        check(out_code == 8'h00, "R7 mid-run reset code", out_code, 0);
        in_vld = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check(out_vld == 1'b0, "R7 no stale result after reset", out_vld, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule